// File: doc/BRIEF.md
# Expansion-Bus Card Configuration Controller

This block sits on an add-in card of a legacy plug-and-play expansion bus and runs the card's side of the configuration protocol. Host software selects a register by writing an index to the address port, then writes or reads that register through the data port. The controller keeps the card in one of four states: waiting for the initiation key, asleep, isolating, or configurable. It also holds the card select number, the read-port address, the selected logical device, and an activate bit and a range-check register for each logical device. The initiation key detector sits outside the block and reports through a one-cycle `key_seen` strobe. The serial-ID comparison and the resource ROM also sit outside. Of the ROM, the block sees only a byte-ready flag, and it sends back a pointer-clear pulse.

While range check is enabled on a device that is not active, the controller answers host I/O reads that fall inside that device's decode window with a fixed test byte. The window of device d starts at `IO_BASE + d*IO_SPAN` and is `IO_SPAN` bytes long. Every bus-side input is a single-cycle strobe that the block always accepts. No input has back-pressure and no ready signal exists. Read data is combinational from the registered state, so it is valid in the same cycle as `dat_rd` or `io_rd`.

Top module: `card_cfg_ctrl`

## Requirements
- R1: After reset the card is waiting for the key (state code 0). The select number is 0, the read-port address is 0, the selected device is 0, and every device is inactive with range check off.
- R2: A `key_seen` strobe moves the card from waiting-for-key (code 0) to sleep (code 1). While the card waits for the key, every data-port write has no effect.
- R3: A wake write (index 0x03) whose data equals the select number moves the card to isolation (code 2) if the data is zero and to config (code 3) otherwise, and pulses `rsrc_ptr_clr` for one cycle. In isolation or config, a wake write whose data does not match returns the card to sleep. In sleep, such a write changes nothing.
- R4: A select-number write (index 0x06) in isolation stores the data and moves the card to config. In config it overwrites the value. In other states it is ignored.
- R5: A config-control write (index 0x02) in sleep, isolation or config acts on each bit independently. Bit 0 clears every device's activate and range-check registers and leaves the state and select number alone. Bit 1 sends the card to waiting-for-key and keeps the select number. Bit 2 clears the select number. Nothing is stored, so a read of index 0x02 returns 0x00.
- R6: In config, a write to index 0x00 sets `rd_port_addr` to the data followed by two zero bits.
- R7: In config, a write to index 0x07 selects a device if the value is below NDEV and is ignored otherwise. A read of index 0x07 returns the selection. With NDEV of 1 it always reads 0x00.
- R8: In config, index 0x30 writes bit 0 as the selected device's activate bit, which drives `dev_active`. A read returns that bit with bits 7:1 zero.
- R9: In config, index 0x31 writes bits 1:0 of the selected device's range-check register: bit 1 enables range check and bit 0 selects the pattern. A read returns those bits with bits 7:2 zero.
- R10: Range check applies to an `io_rd` whose address is inside the window of a device that has range check enabled and is inactive. For such a read, `io_hit` is 1 and `io_rdata` is 0x55 if the pattern bit is set or 0xAA if it is clear. For any other read, `io_hit` is 0 and `io_rdata` is 0x00.
- R11: In config, index 0x05 reads as `rsrc_byte_rdy` in bit 0 with the other bits zero, and index 0x06 reads as the select number. Unlisted indexes read 0x00, and every data-port read outside config returns 0x00.
- R12: Outside config, writes to indexes 0x00, 0x07, 0x30 and 0x31 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_seen | input | 1 | Initiation key detected (strobe) |
| adr_wr | input | 1 | Address-port write strobe |
| adr_wdata | input | 8 | Register index |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Data-port write value |
| dat_rd | input | 1 | Data-port read strobe |
| dat_rdata | output | 8 | Data-port read value |
| rsrc_byte_rdy | input | 1 | Resource byte available |
| rsrc_ptr_clr | output | 1 | One-cycle resource pointer reset |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | AW | Host I/O read address |
| io_hit | output | 1 | Range-check answer driven |
| io_rdata | output | 8 | Range-check test byte |
| card_state | output | 2 | 0 wait key, 1 sleep, 2 isolation, 3 config |
| csn | output | 8 | Card select number |
| dev_active | output | NDEV | Per-device activate bits |
| rd_port_addr | output | 10 | Read-port address |

## Verification
A wrong state is visible on `card_state` in the cycle after the write that caused it. It also changes what the data port returns on the next read, because every register read falls to 0x00 outside config. A wrong device selection shows up as an activate or range-check value landing on the wrong device. That error surfaces at `dev_active` within one cycle and on the next range-check read of either window. A control bit that clears too much or too little shows up at once on `csn`, `dev_active` or the next test-pattern read.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;
  typedef enum logic [1:0] {
    ST_WAITKEY = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_ISOL    = 2'd2,
    ST_CONFIG  = 2'd3
  } card_st_e;

  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_STAT   = 8'h05;
  localparam logic [7:0] IDX_CSN    = 8'h06;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_RCHK   = 8'h31;

  localparam logic [7:0] PAT_SET   = 8'h55;
  localparam logic [7:0] PAT_CLEAR = 8'hAA;
endpackage

// File: rtl/card_cfg_fsm.sv
module card_cfg_fsm
  import card_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_seen,
  input  logic       wake_wr,
  input  logic       csn_wr,
  input  logic [7:0] wdata,
  input  logic       go_waitkey,
  input  logic       clr_csn,
  output card_st_e   state,
  output logic [7:0] csn,
  output logic       ptr_clr
);
  logic wake_match;
  card_st_e wake_dest;

  assign wake_match = (wdata == csn);
  assign wake_dest  = (wdata == 8'h00) ? ST_ISOL : ST_CONFIG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_WAITKEY;
      csn     <= 8'h00;
      ptr_clr <= 1'b0;
    end else begin
      ptr_clr <= 1'b0;
      unique case (state)
        ST_WAITKEY: if (key_seen) state <= ST_SLEEP;
        ST_SLEEP: begin
          if (wake_wr && wake_match) begin
            state   <= wake_dest;
            ptr_clr <= 1'b1;
          end
        end
        ST_ISOL, ST_CONFIG: begin
          if (wake_wr) begin
            if (wake_match) begin
              state   <= wake_dest;
              ptr_clr <= 1'b1;
            end else begin
              state <= ST_SLEEP;
            end
          end else if (csn_wr) begin
            csn   <= wdata;
            state <= ST_CONFIG;
          end
        end
        default: state <= ST_WAITKEY;
      endcase
      if (go_waitkey) state <= ST_WAITKEY;
      if (clr_csn) csn <= 8'h00;
    end
  end
endmodule

// File: rtl/card_dev_regs.sv
module card_dev_regs #(
  parameter int NDEV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dev_rst,
  input  logic [NDEV-1:0]      sel,
  input  logic                 act_wr,
  input  logic                 rc_wr,
  input  logic [7:0]           wdata,
  output logic [NDEV-1:0]      act,
  output logic [NDEV-1:0][1:0] rc
);
  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rst_n || dev_rst) begin
        act[d] <= 1'b0;
        rc[d]  <= 2'b00;
      end else if (sel[d]) begin
        if (act_wr) act[d] <= wdata[0];
        if (rc_wr)  rc[d]  <= wdata[1:0];
      end
    end
  end
endmodule

// File: rtl/card_range_resp.sv
module card_range_resp
  import card_cfg_pkg::*;
#(
  parameter int              NDEV    = 2,
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   IO_BASE = 16'h0300,
  parameter logic [AW-1:0]   IO_SPAN = 16'h0008
) (
  input  logic                 io_rd,
  input  logic [AW-1:0]        io_addr,
  input  logic [NDEV-1:0]      act,
  input  logic [NDEV-1:0][1:0] rc,
  output logic                 hit,
  output logic [7:0]           data
);
  logic [NDEV-1:0]      dev_hit;
  logic [NDEV-1:0][7:0] dev_data;

  for (genvar d = 0; d < NDEV; d++) begin : g_win
    localparam logic [AW-1:0] LO = IO_BASE + AW'(d) * IO_SPAN;
    localparam logic [AW-1:0] HI = LO + IO_SPAN;
    logic in_win;
    assign in_win      = (io_addr >= LO) && (io_addr < HI);
    assign dev_hit[d]  = io_rd && in_win && rc[d][1] && !act[d];
    assign dev_data[d] = dev_hit[d] ? (rc[d][0] ? PAT_SET : PAT_CLEAR) : 8'h00;
  end

  always_comb begin
    data = 8'h00;
    for (int d = 0; d < NDEV; d++) data = data | dev_data[d];
  end
  assign hit = |dev_hit;
endmodule

// File: rtl/card_cfg_ctrl.sv
module card_cfg_ctrl
  import card_cfg_pkg::*;
#(
  parameter int            NDEV    = 2,
  parameter int            AW      = 16,
  parameter logic [AW-1:0] IO_BASE = 16'h0300,
  parameter logic [AW-1:0] IO_SPAN = 16'h0008
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_seen,
  input  logic            adr_wr,
  input  logic [7:0]      adr_wdata,
  input  logic            dat_wr,
  input  logic [7:0]      dat_wdata,
  input  logic            dat_rd,
  output logic [7:0]      dat_rdata,
  input  logic            rsrc_byte_rdy,
  output logic            rsrc_ptr_clr,
  input  logic            io_rd,
  input  logic [AW-1:0]   io_addr,
  output logic            io_hit,
  output logic [7:0]      io_rdata,
  output logic [1:0]      card_state,
  output logic [7:0]      csn,
  output logic [NDEV-1:0] dev_active,
  output logic [9:0]      rd_port_addr
);
  localparam int LDW = (NDEV > 1) ? $clog2(NDEV) : 1;

  card_st_e             state_q;
  logic [7:0]           idx_q;
  logic [LDW-1:0]       ldn_q;
  logic [NDEV-1:0]      sel;
  logic [NDEV-1:0]      act_q;
  logic [NDEV-1:0][1:0] rc_q;
  logic                 awake, in_cfg;
  logic                 wake_wr, csn_wr, ctrl_wr, cfg_wr;
  logic                 sel_act;
  logic [1:0]           sel_rc;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 8'h00;
    else if (adr_wr) idx_q <= adr_wdata;
  end

  assign awake   = (state_q != ST_WAITKEY);
  assign in_cfg  = (state_q == ST_CONFIG);
  assign wake_wr = dat_wr && awake && (idx_q == IDX_WAKE);
  assign ctrl_wr = dat_wr && awake && (idx_q == IDX_CTRL);
  assign csn_wr  = dat_wr && (idx_q == IDX_CSN) &&
                   ((state_q == ST_ISOL) || in_cfg);
  assign cfg_wr  = dat_wr && in_cfg;

  card_cfg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_seen   (key_seen),
    .wake_wr    (wake_wr),
    .csn_wr     (csn_wr),
    .wdata      (dat_wdata),
    .go_waitkey (ctrl_wr && dat_wdata[1]),
    .clr_csn    (ctrl_wr && dat_wdata[2]),
    .state      (state_q),
    .csn        (csn),
    .ptr_clr    (rsrc_ptr_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_port_addr <= 10'h000;
    else if (cfg_wr && idx_q == IDX_RDPORT) rd_port_addr <= {dat_wdata, 2'b00};
  end

  if (NDEV > 1) begin : g_multi
    always_ff @(posedge clk) begin
      if (!rst_n) ldn_q <= '0;
      else if (cfg_wr && idx_q == IDX_LDN && int'(dat_wdata) < NDEV)
        ldn_q <= dat_wdata[LDW-1:0];
    end
  end else begin : g_single
    assign ldn_q = '0;
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_sel
    assign sel[d] = (int'(ldn_q) == d);
  end

  card_dev_regs #(.NDEV(NDEV)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_rst (ctrl_wr && dat_wdata[0]),
    .sel     (sel),
    .act_wr  (cfg_wr && idx_q == IDX_ACT),
    .rc_wr   (cfg_wr && idx_q == IDX_RCHK),
    .wdata   (dat_wdata),
    .act     (act_q),
    .rc      (rc_q)
  );

  card_range_resp #(
    .NDEV(NDEV), .AW(AW), .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN)
  ) u_resp (
    .io_rd   (io_rd),
    .io_addr (io_addr),
    .act     (act_q),
    .rc      (rc_q),
    .hit     (io_hit),
    .data    (io_rdata)
  );

  always_comb begin
    sel_act = 1'b0;
    sel_rc  = 2'b00;
    for (int d = 0; d < NDEV; d++) begin
      if (sel[d]) begin
        sel_act = act_q[d];
        sel_rc  = rc_q[d];
      end
    end
  end

  always_comb begin
    dat_rdata = 8'h00;
    if (dat_rd && in_cfg) begin
      unique case (idx_q)
        IDX_STAT: dat_rdata = {7'b0, rsrc_byte_rdy};
        IDX_CSN:  dat_rdata = csn;
        IDX_LDN:  dat_rdata = 8'(ldn_q);
        IDX_ACT:  dat_rdata = {7'b0, sel_act};
        IDX_RCHK: dat_rdata = {6'b0, sel_rc};
        default:  dat_rdata = 8'h00;
      endcase
    end
  end

  assign card_state = state_q;
  assign dev_active = act_q;
endmodule

// File: rtl/card_cfg_chk.sv
module card_cfg_chk
  import card_cfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       key_seen,
  input logic       dat_wr,
  input logic [7:0] idx,
  input logic [7:0] dat_wdata,
  input logic [1:0] state,
  input logic [7:0] csn,
  input logic       ptr_clr,
  input logic       io_hit,
  input logic [7:0] io_rdata
);
  a_r2_key_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITKEY && key_seen) |=> state == ST_SLEEP);

  a_r2_waitkey_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITKEY && !key_seen) |=> (state == ST_WAITKEY && $stable(csn)));

  a_r3_wake_to_config: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && dat_wr && idx == IDX_WAKE && dat_wdata == csn && dat_wdata != 8'h00)
    |=> (state == ST_CONFIG && ptr_clr));

  a_r3_wake_to_isol: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && dat_wr && idx == IDX_WAKE && dat_wdata == 8'h00 && csn == 8'h00)
    |=> (state == ST_ISOL && ptr_clr));

  a_r10_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_rdata == PAT_SET || io_rdata == PAT_CLEAR));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> io_rdata == 8'h00);
endmodule

bind card_cfg_ctrl card_cfg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_seen  (key_seen),
  .dat_wr    (dat_wr),
  .idx       (idx_q),
  .dat_wdata (dat_wdata),
  .state     (card_state),
  .csn       (csn),
  .ptr_clr   (rsrc_ptr_clr),
  .io_hit    (io_hit),
  .io_rdata  (io_rdata)
);

// File: tb/card_cfg_ctrl_tb_top.sv
`timescale 1ns/100ps
module card_cfg_ctrl_tb_top;
  localparam int NDEV = 2;
  localparam int AW   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            key_seen = 1'b0;
  logic            adr_wr = 1'b0;
  logic [7:0]      adr_wdata = 8'h00;
  logic            dat_wr = 1'b0;
  logic [7:0]      dat_wdata = 8'h00;
  logic            dat_rd = 1'b0;
  logic [7:0]      dat_rdata;
  logic            rsrc_byte_rdy = 1'b0;
  logic            rsrc_ptr_clr;
  logic            io_rd = 1'b0;
  logic [AW-1:0]   io_addr = '0;
  logic            io_hit;
  logic [7:0]      io_rdata;
  logic [1:0]      card_state;
  logic [7:0]      csn;
  logic [NDEV-1:0] dev_active;
  logic [9:0]      rd_port_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [8:0] val;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  card_cfg_ctrl #(.NDEV(NDEV), .AW(AW), .IO_BASE(16'h0300), .IO_SPAN(16'h0008)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_seen(key_seen),
    .adr_wr(adr_wr), .adr_wdata(adr_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .rsrc_byte_rdy(rsrc_byte_rdy), .rsrc_ptr_clr(rsrc_ptr_clr),
    .io_rd(io_rd), .io_addr(io_addr), .io_hit(io_hit), .io_rdata(io_rdata),
    .card_state(card_state), .csn(csn), .dev_active(dev_active),
    .rd_port_addr(rd_port_addr)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compares every read strobe against the scoreboard queue
  always @(negedge clk) begin
    if (dat_rd || io_rd) begin
      logic [8:0] got;
      got = io_rd ? {io_hit, io_rdata} : {1'b0, dat_rdata};
      if (sb_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: unexpected read, got %h expected none", got);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, 16'(got), 16'(e.val));
      end
    end
  end

  task automatic set_idx(logic [7:0] idx);
    @(posedge clk); #1 adr_wr = 1'b1; adr_wdata = idx;
    @(posedge clk); #1 adr_wr = 1'b0;
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    set_idx(idx);
    dat_wr = 1'b1; dat_wdata = d;
    @(posedge clk); #1 dat_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] idx, logic [7:0] exp, string req);
    exp_t e;
    set_idx(idx);
    e.val = {1'b0, exp}; e.req = req;
    sb_q.push_back(e);
    dat_rd = 1'b1;
    @(posedge clk); #1 dat_rd = 1'b0;
  endtask

  task automatic iord(logic [AW-1:0] a, logic hit, logic [7:0] exp, string req);
    exp_t e;
    @(posedge clk); #1;
    e.val = {hit, exp}; e.req = req;
    sb_q.push_back(e);
    io_rd = 1'b1; io_addr = a;
    @(posedge clk); #1 io_rd = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 state", 16'(card_state), 16'd0);
    chk("R1 csn", 16'(csn), 16'd0);
    chk("R1 active", 16'(dev_active), 16'd0);
    chk("R1 rdport", 16'(rd_port_addr), 16'd0);
    iord(16'h0302, 1'b0, 8'h00, "R1 no range check");

    // R2 wait-for-key ignores data writes
    wr(8'h03, 8'h00);
    chk("R2 wake ignored in waitkey", 16'(card_state), 16'd0);
    @(posedge clk); #1 key_seen = 1'b1;
    @(posedge clk); #1 key_seen = 1'b0;
    chk("R2 key to sleep", 16'(card_state), 16'd1);

    // R3 wake in sleep
    wr(8'h03, 8'h05);
    chk("R3 nonmatch stays sleep", 16'(card_state), 16'd1);
    wr(8'h03, 8'h00);
    chk("R3 zero wake to isolation", 16'(card_state), 16'd2);
    chk("R3 pointer clear pulse", 16'(rsrc_ptr_clr), 16'd1);
    @(posedge clk); #1;
    chk("R3 pointer clear one cycle", 16'(rsrc_ptr_clr), 16'd0);

    // R12 config-only writes ignored in isolation
    wr(8'h07, 8'h01);
    // R4 select number in isolation
    wr(8'h06, 8'h07);
    chk("R4 csn stored", 16'(csn), 16'h07);
    chk("R4 isolation to config", 16'(card_state), 16'd3);
    rd(8'h07, 8'h00, "R12 ldn write ignored in isolation");
    rd(8'h06, 8'h07, "R11 csn read");

    // R7 device select
    wr(8'h07, 8'h01);
    rd(8'h07, 8'h01, "R7 ldn select");
    wr(8'h07, 8'h05);
    rd(8'h07, 8'h01, "R7 out of range ignored");

    // R8 activate on device 1
    wr(8'h30, 8'hFF);
    rd(8'h30, 8'h01, "R8 activate read");
    chk("R8 dev_active", 16'(dev_active), 16'h2);

    // R9 / R10 range check on device 0
    wr(8'h07, 8'h00);
    rd(8'h30, 8'h00, "R8 device 0 inactive");
    wr(8'h31, 8'hFF);
    rd(8'h31, 8'h03, "R9 range check read");
    iord(16'h0303, 1'b1, 8'h55, "R10 pattern 55");
    wr(8'h31, 8'h02);
    iord(16'h0307, 1'b1, 8'hAA, "R10 pattern AA");
    iord(16'h0308, 1'b0, 8'h00, "R10 outside window");
    iord(16'h02FF, 1'b0, 8'h00, "R10 below window");

    // R6 read-port address
    wr(8'h00, 8'h9C);
    chk("R6 rd_port_addr", 16'(rd_port_addr), 16'h270);

    // R11 status and unlisted
    rsrc_byte_rdy = 1'b1;
    rd(8'h05, 8'h01, "R11 status ready");
    rsrc_byte_rdy = 1'b0;
    rd(8'h05, 8'h00, "R11 status idle");
    rd(8'h20, 8'h00, "R11 unlisted index");
    rd(8'h02, 8'h00, "R5 control reads zero");

    // R3 nonmatching wake in config to sleep
    wr(8'h03, 8'h03);
    chk("R3 nonmatch to sleep", 16'(card_state), 16'd1);
    rd(8'h06, 8'h00, "R11 read outside config");
    wr(8'h30, 8'h00);
    chk("R12 activate ignored in sleep", 16'(dev_active), 16'h2);
    wr(8'h03, 8'h07);
    chk("R3 matching wake to config", 16'(card_state), 16'd3);
    chk("R3 pointer clear on config wake", 16'(rsrc_ptr_clr), 16'd1);

    // R5 control bits
    wr(8'h02, 8'h01);
    chk("R5 devices reset", 16'(dev_active), 16'h0);
    chk("R5 csn kept", 16'(csn), 16'h07);
    chk("R5 state kept", 16'(card_state), 16'd3);
    iord(16'h0303, 1'b0, 8'h00, "R5 range check cleared");
    wr(8'h02, 8'h04);
    chk("R5 csn cleared", 16'(csn), 16'h00);
    wr(8'h06, 8'h09);
    wr(8'h02, 8'h02);
    chk("R5 to waitkey", 16'(card_state), 16'd0);
    chk("R5 csn kept on waitkey", 16'(csn), 16'h09);

    repeat (3) @(posedge clk);
    #1;
    chk("scoreboard drained", 16'(sb_q.size()), 16'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule